// File: doc/BRIEF.md
# Span Z and Color Interpolator

The block walks one horizontal span of a rasterised primitive, one pixel per clock. A start pulse captures an initial depth value, initial red, green and blue intensities, a per-pixel slope for each, a base address, the low two bits of the starting column and of the row, a signed pixel count and a set of mode bits. For every pixel the block steps the depth and the colors by their slopes. It reads the depth already stored at the pixel's address through a combinational read port and tests the new depth against it with a selectable relation. A 4x4 ordered screen-door pattern then gates the result. When both the test and the pattern allow it, the block drives a write of address, color and new depth for that cycle.

Depth is held as fixed point with 12 fraction bits and either 16 or 24 integer bits. In the 24-bit form the fraction arrives as an upper eight-bit piece and a lower four-bit piece. Colors are 8.12 unsigned values stepped by signed 8.12 slopes, and they clamp at their limits. Mode bits can freeze depth stepping, color stepping or address stepping independently, and a single-index color mode silences the red and green channels. Setup of the span values is done upstream.

Top module: `span_interp`

## Requirements
- R1: A start pulse while idle with a nonzero count raises busy for exactly |count| cycles, one pixel per cycle, then done is high for one cycle with busy low; a zero count gives the done pulse one cycle after start with no busy cycle and no write; a start while busy is ignored.
- R2: span_cnt is a 13-bit two's complement count; pixel k has address base_addr+k when the count is positive and base_addr-k when negative, and the column phase moves the same way modulo 4.
- R3: Depth input is {z_int, z_frac_hi, z_frac_lo} (24.12) and the slope is {zs_int, zs_frac_hi, zs_frac_lo}; pixel k depth is init+k*slope modulo 2^36 in 24-bit mode, and in 16-bit mode only z_int[15:0] and zs_int[15:0] count and the sum wraps modulo 2^28; pix_z is the integer part (bits 23:16 zero in 16-bit mode).
- R4: zcmp[2] enables new<stored, zcmp[1] enables new>stored, zcmp[0] enables equality, unsigned on the integer part; a pixel passes when any enabled relation holds; in 16-bit mode only zbuf_rdata[15:0] is compared.
- R5: door_mask bit 4*row_phase+column_phase set to 1 suppresses the write of that pixel.
- R6: Each color channel steps init+k*slope (signed slope) and clamps to 0 and 255.fff; pix_color is {red[23:16], green[15:8], blue[7:0]} integer parts.
- R7: hold_z keeps pix_z at the initial value, hold_color keeps all colors at their initial values, hold_addr keeps pix_addr at base_addr for the whole span.
- R8: With index_mode set, pix_color[23:8] is zero and pix_color[7:0] carries the blue channel.
- R9: After reset busy, done and pix_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a span (ignored while busy) |
| hold_z | input | 1 | Freeze depth stepping |
| hold_color | input | 1 | Freeze color stepping |
| hold_addr | input | 1 | Freeze address stepping |
| index_mode | input | 1 | Single index channel on blue; red and green zero |
| z_wide | input | 1 | 1: 24-bit integer depth, 0: 16-bit |
| zcmp | input | 3 | Enabled relations: less, greater, equal |
| door_mask | input | 16 | Screen-door suppress pattern |
| span_cnt | input | 13 | Signed pixel count |
| base_addr | input | AW | Address of the first pixel |
| col_phase | input | 2 | Low bits of starting column |
| row_phase | input | 2 | Low bits of row |
| z_int | input | 24 | Initial depth integer part |
| z_frac_hi | input | 8 | Initial depth fraction, upper bits |
| z_frac_lo | input | 4 | Initial depth fraction, lower bits |
| zs_int | input | 24 | Depth slope integer part |
| zs_frac_hi | input | 8 | Depth slope fraction, upper bits |
| zs_frac_lo | input | 4 | Depth slope fraction, lower bits |
| r_init | input | 20 | Red initial value, 8.12 |
| r_slope | input | 20 | Red slope, signed 8.12 |
| g_init | input | 20 | Green initial value |
| g_slope | input | 20 | Green slope |
| b_init | input | 20 | Blue initial value |
| b_slope | input | 20 | Blue slope |
| zbuf_rdata | input | 24 | Stored depth at pix_addr (combinational read) |
| pix_we | output | 1 | Pixel write strobe |
| pix_addr | output | AW | Current pixel address (read and write) |
| pix_color | output | 24 | Pixel color |
| pix_z | output | 24 | New depth integer part |
| busy | output | 1 | Span in progress |
| done | output | 1 | One-cycle end-of-span pulse |

## Verification
The hardest situation to reach is a pixel whose depth test depends on a write made by the previous pixel, which only happens when address stepping is frozen so consecutive pixels land on one location. The stimulus holds the address with a rising depth slope over a stored value above the first depth, so the first pixel writes and the later ones must fail against the freshly written value. Depth wrap in the 16-bit form is reached by starting at the top of the range with garbage in the upper integer bits, and clamping by slopes that cross both color limits within a few pixels.

// File: rtl/span_pkg.sv
// Shared types for the span interpolator.
// Assumes a 4x4 screen-door pattern, so the mask is always 16 bits.
package span_pkg;
    localparam int MASK_W = 16;

    typedef struct packed {
        logic              zhold;
        logic              chold;
        logic              ahold;
        logic              index_mode;
        logic              z24;
        logic [2:0]        cmp;
        logic [MASK_W-1:0] mask;
        logic [1:0]        row;
    } span_cfg_t;
endpackage

// File: rtl/span_ctrl.sv
// Span sequencer: accepts a start while idle, latches the mode word,
// counts |span_cnt| pixels and moves address and column phase up or down.
// Assumes span_cnt is two's complement; the magnitude fits in CW bits unsigned.
module span_ctrl
    import span_pkg::*;
#(
    parameter int AW = 20,
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  span_cfg_t     cfg_in,
    input  logic [CW-1:0] span_cnt,
    input  logic [AW-1:0] base_addr,
    input  logic [1:0]    col_phase,
    output logic          load,
    output logic          busy,
    output logic          done,
    output logic          dir_neg,
    output logic [AW-1:0] addr,
    output logic [1:0]    x_ph,
    output span_cfg_t     cfg_q
);
    logic [CW-1:0] remain;
    logic [CW-1:0] mag;

    // Accept a start only while idle.
    assign load = start && !busy;
    // Unsigned pixel count from the signed request.
    assign mag  = span_cnt[CW-1] ? (~span_cnt + 1'b1) : span_cnt;

    // Sequencer state: count, direction, position, latched modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            remain  <= '0;
            dir_neg <= 1'b0;
            addr    <= '0;
            x_ph    <= '0;
            cfg_q   <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                cfg_q   <= cfg_in;
                dir_neg <= span_cnt[CW-1];
                remain  <= mag;
                addr    <= base_addr;
                x_ph    <= col_phase;
                if (mag == '0) begin
                    done <= 1'b1;
                end else begin
                    busy <= 1'b1;
                end
            end else if (busy) begin
                remain <= remain - 1'b1;
                if (remain == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
                if (!cfg_q.ahold) begin
                    addr <= dir_neg ? addr - 1'b1 : addr + 1'b1;
                end
                x_ph <= dir_neg ? x_ph - 1'b1 : x_ph + 1'b1;
            end
        end
    end
endmodule

// File: rtl/span_color.sv
// One color channel: unsigned IW.FW accumulator stepped by a signed slope,
// clamped to zero and full scale instead of wrapping.
// Assumes the slope magnitude is below full scale.
module span_color #(
    parameter int IW = 8,
    parameter int FW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [IW+FW-1:0] init,
    input  logic [IW+FW-1:0] slope,
    output logic [IW-1:0]   value
);
    localparam int W = IW + FW;

    logic [W-1:0] acc;
    logic [W-1:0] slope_q;
    logic [W+1:0] sum;
    logic [W-1:0] nxt;

    // Two guard bits: top one flags underflow, next one overflow.
    assign sum = {2'b00, acc} + {{2{slope_q[W-1]}}, slope_q};

    // Clamp the stepped value into the unsigned range.
    always_comb begin
        if (sum[W+1]) begin
            nxt = '0;
        end else if (sum[W]) begin
            nxt = '1;
        end else begin
            nxt = sum[W-1:0];
        end
    end

    // Accumulator and latched slope.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            slope_q <= '0;
        end else if (load) begin
            acc     <= init;
            slope_q <= slope;
        end else if (step) begin
            acc <= nxt;
        end
    end

    assign value = acc[W-1:FW];
endmodule

// File: rtl/span_depth.sv
// Depth accumulator and depth test. Holds ZI.ZF fixed point; in narrow mode
// the value is kept modulo 2^(ZN+ZF) and only ZN integer bits are compared.
// Assumes the stored depth is presented combinationally for the current pixel.
module span_depth #(
    parameter int ZI = 24,
    parameter int ZF = 12,
    parameter int ZN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          wide_ld,
    input  logic          wide_run,
    input  logic [ZI+ZF-1:0] init_raw,
    input  logic [ZI+ZF-1:0] slope_raw,
    input  logic [2:0]    cmp,
    input  logic [ZI-1:0] stored,
    output logic [ZI-1:0] z_now,
    output logic          pass
);
    localparam int ZW = ZI + ZF;
    localparam int NW = ZN + ZF;
    localparam logic [ZW-1:0] NARROW = {{(ZW-NW){1'b0}}, {NW{1'b1}}};
    localparam logic [ZI-1:0] NARROW_I = {{(ZI-ZN){1'b0}}, {ZN{1'b1}}};

    logic [ZW-1:0] acc;
    logic [ZW-1:0] slope_q;
    logic [ZW-1:0] sum;
    logic [ZI-1:0] old_z;
    logic          lt, gt, eq;

    // Step and fold into the active precision.
    assign sum = wide_run ? (acc + slope_q) : ((acc + slope_q) & NARROW);

    // Accumulator and latched slope.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            slope_q <= '0;
        end else if (load) begin
            acc     <= wide_ld ? init_raw : (init_raw & NARROW);
            slope_q <= slope_raw;
        end else if (step) begin
            acc <= sum;
        end
    end

    assign z_now = acc[ZW-1:ZF];

    // Relation test against the stored depth in the active precision.
    always_comb begin
        old_z = wide_run ? stored : (stored & NARROW_I);
        lt    = z_now < old_z;
        gt    = z_now > old_z;
        eq    = z_now == old_z;
        pass  = (cmp[2] && lt) || (cmp[1] && gt) || (cmp[0] && eq);
    end
endmodule

// File: rtl/span_interp.sv
// Span Z and color interpolator top. One pixel per cycle while busy; the
// write strobe is combinational from the current pixel state and zbuf_rdata.
// Assumes the depth store writes on the clock edge that ends the pixel cycle.
module span_interp
    import span_pkg::*;
#(
    parameter int AW    = 20,
    parameter int CW    = 13,
    parameter int ZI    = 24,
    parameter int ZF    = 12,
    parameter int ZN    = 16,
    parameter int ZF_LO = 4,
    parameter int CI    = 8,
    parameter int CF    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               hold_z,
    input  logic               hold_color,
    input  logic               hold_addr,
    input  logic               index_mode,
    input  logic               z_wide,
    input  logic [2:0]         zcmp,
    input  logic [MASK_W-1:0]  door_mask,
    input  logic [CW-1:0]      span_cnt,
    input  logic [AW-1:0]      base_addr,
    input  logic [1:0]         col_phase,
    input  logic [1:0]         row_phase,
    input  logic [ZI-1:0]      z_int,
    input  logic [ZF-ZF_LO-1:0] z_frac_hi,
    input  logic [ZF_LO-1:0]   z_frac_lo,
    input  logic [ZI-1:0]      zs_int,
    input  logic [ZF-ZF_LO-1:0] zs_frac_hi,
    input  logic [ZF_LO-1:0]   zs_frac_lo,
    input  logic [CI+CF-1:0]   r_init,
    input  logic [CI+CF-1:0]   r_slope,
    input  logic [CI+CF-1:0]   g_init,
    input  logic [CI+CF-1:0]   g_slope,
    input  logic [CI+CF-1:0]   b_init,
    input  logic [CI+CF-1:0]   b_slope,
    input  logic [ZI-1:0]      zbuf_rdata,
    output logic               pix_we,
    output logic [AW-1:0]      pix_addr,
    output logic [3*CI-1:0]    pix_color,
    output logic [ZI-1:0]      pix_z,
    output logic               busy,
    output logic               done
);
    localparam int NCH = 3;

    span_cfg_t      cfg_in, cfg_q;
    logic           load, dir_neg, zpass, door_hit;
    logic [1:0]     x_ph;
    logic [CI+CF-1:0] ch_init  [NCH];
    logic [CI+CF-1:0] ch_slope [NCH];
    logic [CI-1:0]    ch_val   [NCH];

    // Gather the mode word captured at start.
    always_comb begin
        cfg_in.zhold      = hold_z;
        cfg_in.chold      = hold_color;
        cfg_in.ahold      = hold_addr;
        cfg_in.index_mode = index_mode;
        cfg_in.z24        = z_wide;
        cfg_in.cmp        = zcmp;
        cfg_in.mask       = door_mask;
        cfg_in.row        = row_phase;
    end

    span_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in),
        .span_cnt(span_cnt), .base_addr(base_addr), .col_phase(col_phase),
        .load(load), .busy(busy), .done(done), .dir_neg(dir_neg),
        .addr(pix_addr), .x_ph(x_ph), .cfg_q(cfg_q)
    );

    span_depth #(.ZI(ZI), .ZF(ZF), .ZN(ZN)) u_depth (
        .clk(clk), .rst_n(rst_n), .load(load),
        .step(busy && !cfg_q.zhold),
        .wide_ld(z_wide), .wide_run(cfg_q.z24),
        .init_raw({z_int, z_frac_hi, z_frac_lo}),
        .slope_raw({zs_int, zs_frac_hi, zs_frac_lo}),
        .cmp(cfg_q.cmp), .stored(zbuf_rdata),
        .z_now(pix_z), .pass(zpass)
    );

    // Channel order: 0 red, 1 green, 2 blue.
    assign ch_init[0]  = r_init;
    assign ch_init[1]  = g_init;
    assign ch_init[2]  = b_init;
    assign ch_slope[0] = r_slope;
    assign ch_slope[1] = g_slope;
    assign ch_slope[2] = b_slope;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        span_color #(.IW(CI), .FW(CF)) u_col (
            .clk(clk), .rst_n(rst_n), .load(load),
            .step(busy && !cfg_q.chold),
            .init(ch_init[c]), .slope(ch_slope[c]),
            .value(ch_val[c])
        );
    end

    // Output color with red and green silenced in index mode.
    assign pix_color = cfg_q.index_mode ? {{(2*CI){1'b0}}, ch_val[2]}
                                        : {ch_val[0], ch_val[1], ch_val[2]};

    // Screen-door lookup on row and column phase, then the write decision.
    assign door_hit = cfg_q.mask[{cfg_q.row, x_ph}];
    assign pix_we   = busy && zpass && !door_hit;
endmodule

// File: rtl/span_interp_chk.sv
// Property checker for span_interp, bound to every instance.
module span_interp_chk
    import span_pkg::*;
#(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          pix_we,
    input logic [AW-1:0] pix_addr,
    input logic [23:0]   pix_z,
    input logic [23:0]   pix_color,
    input span_cfg_t     cfg_q,
    input logic [1:0]    x_ph,
    input logic          dir_neg
);
    AST_WE_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> busy); // R1
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R1
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !cfg_q.ahold) |->
        pix_addr == (dir_neg ? AW'($past(pix_addr) - 1'b1) : AW'($past(pix_addr) + 1'b1))); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && cfg_q.ahold) |-> $stable(pix_addr)); // R7
    AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && cfg_q.zhold) |-> $stable(pix_z)); // R7
    AST_NARROW_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cfg_q.z24) |-> pix_z[23:16] == 8'h00); // R3
    AST_INDEX_RG: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_q.index_mode) |-> pix_color[23:8] == 16'h0000); // R8
    AST_DOOR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pix_we |-> !cfg_q.mask[{cfg_q.row, x_ph}]); // R5
endmodule

bind span_interp span_interp_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pix_we(pix_we),
    .pix_addr(pix_addr), .pix_z(pix_z), .pix_color(pix_color),
    .cfg_q(cfg_q), .x_ph(x_ph), .dir_neg(dir_neg)
);

// File: tb/test_span_interp.sv
module test_span_interp;
    typedef struct packed {
        logic signed [12:0] cnt;
        logic [2:0]  cmp;
        logic [15:0] mask;
        logic [4:0]  fl;     // {hold_z, hold_color, hold_addr, index_mode, z_wide}
        logic [1:0]  col;
        logic [1:0]  row;
        logic [35:0] z0;
        logic [35:0] zs;
        logic [19:0] r, rs, g, gs, b, bs;
        logic [23:0] fill;
        logic [5:0]  base;
        logic [7:0]  expw;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R6 basic stepping, always-write
        '{13'sd4, 3'b111, 16'h0000, 5'b00000, 2'd0, 2'd0, 36'h00000A000, 36'h000002000,
          20'h0A000, 20'h01000, 20'h00000, 20'h00000, 20'hC8000, 20'h01800, 24'd0, 6'd8, 8'd4},
        // R4 less
        '{13'sd4, 3'b100, 16'h0000, 5'b00000, 2'd0, 2'd0, 36'h00000A000, 36'h000002000,
          20'h0A000, 20'h01000, 20'h00000, 20'h00000, 20'hC8000, 20'h01800, 24'd13, 6'd8, 8'd2},
        // R4 greater
        '{13'sd4, 3'b010, 16'h0000, 5'b00000, 2'd0, 2'd0, 36'h00000A000, 36'h000002000,
          20'h0A000, 20'h01000, 20'h00000, 20'h00000, 20'hC8000, 20'h01800, 24'd13, 6'd8, 8'd2},
        // R4 equal
        '{13'sd4, 3'b001, 16'h0000, 5'b00000, 2'd0, 2'd0, 36'h00000A000, 36'h000002000,
          20'h0A000, 20'h01000, 20'h00000, 20'h00000, 20'hC8000, 20'h01800, 24'd12, 6'd8, 8'd1},
        // R5 mask bits 5 and 7 on row 1
        '{13'sd4, 3'b111, 16'h00A0, 5'b00000, 2'd0, 2'd1, 36'h00000A000, 36'h000002000,
          20'h0A000, 20'h01000, 20'h00000, 20'h00000, 20'hC8000, 20'h01800, 24'd0, 6'd8, 8'd2},
        // R2 negative count, phase wraps 1,0,3 with bit 3 masked
        '{-13'sd3, 3'b111, 16'h0008, 5'b00000, 2'd1, 2'd0, 36'h00000A000, 36'h000002000,
          20'h0A000, 20'h01000, 20'h00000, 20'h00000, 20'hC8000, 20'h01800, 24'd0, 6'd40, 8'd2},
        // R6 clamp high (red) and low (blue)
        '{13'sd4, 3'b111, 16'h0000, 5'b00000, 2'd0, 2'd0, 36'h00000A000, 36'h000002000,
          20'hFA000, 20'h03000, 20'h80000, 20'h00000, 20'h05000, 20'hFD000, 24'd0, 6'd8, 8'd4},
        // R3 wide depth with split fraction carry
        '{13'sd4, 3'b100, 16'h0000, 5'b00001, 2'd0, 2'd0, 36'h123456801, 36'h0001007FF,
          20'h0A000, 20'h01000, 20'h00000, 20'h00000, 20'hC8000, 20'h01800, 24'h123500, 6'd8, 8'd1},
        // R3 narrow wrap, upper bits ignored
        '{13'sd3, 3'b100, 16'h0000, 5'b00000, 2'd0, 2'd0, 36'hABFFFF000, 36'h000001000,
          20'h0A000, 20'h01000, 20'h00000, 20'h00000, 20'hC8000, 20'h01800, 24'hAB0100, 6'd8, 8'd2},
        // R7 depth hold
        '{13'sd3, 3'b111, 16'h0000, 5'b10000, 2'd0, 2'd0, 36'h000014000, 36'h000005000,
          20'h0A000, 20'h01000, 20'h00000, 20'h00000, 20'hC8000, 20'h01800, 24'd0, 6'd8, 8'd3},
        // R8 index mode with color hold
        '{13'sd2, 3'b111, 16'h0000, 5'b01010, 2'd0, 2'd0, 36'h00000A000, 36'h000002000,
          20'h64000, 20'h01000, 20'h32000, 20'h00000, 20'h07000, 20'h01000, 24'd0, 6'd8, 8'd2},
        // R7 address hold: later pixels test against the first write
        '{13'sd3, 3'b100, 16'h0000, 5'b00100, 2'd0, 2'd0, 36'h000032000, 36'h000001000,
          20'h0A000, 20'h01000, 20'h00000, 20'h00000, 20'hC8000, 20'h01800, 24'd100, 6'd20, 8'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic hold_z = 1'b0, hold_color = 1'b0, hold_addr = 1'b0, index_mode = 1'b0, z_wide = 1'b0;
    logic [2:0]  zcmp = '0;
    logic [15:0] door_mask = '0;
    logic [12:0] span_cnt = '0;
    logic [19:0] base_addr = '0;
    logic [1:0]  col_phase = '0, row_phase = '0;
    logic [23:0] z_int = '0, zs_int = '0;
    logic [7:0]  z_frac_hi = '0, zs_frac_hi = '0;
    logic [3:0]  z_frac_lo = '0, zs_frac_lo = '0;
    logic [19:0] r_init = '0, r_slope = '0, g_init = '0, g_slope = '0, b_init = '0, b_slope = '0;
    logic [23:0] zbuf_rdata;
    logic        pix_we, busy, done;
    logic [19:0] pix_addr;
    logic [23:0] pix_color, pix_z;
    logic [23:0] zmem [64];

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    span_interp i_span_interp (
        .clk(clk), .rst_n(rst_n), .start(start), .hold_z(hold_z), .hold_color(hold_color),
        .hold_addr(hold_addr), .index_mode(index_mode), .z_wide(z_wide), .zcmp(zcmp),
        .door_mask(door_mask), .span_cnt(span_cnt), .base_addr(base_addr),
        .col_phase(col_phase), .row_phase(row_phase), .z_int(z_int), .z_frac_hi(z_frac_hi),
        .z_frac_lo(z_frac_lo), .zs_int(zs_int), .zs_frac_hi(zs_frac_hi), .zs_frac_lo(zs_frac_lo),
        .r_init(r_init), .r_slope(r_slope), .g_init(g_init), .g_slope(g_slope),
        .b_init(b_init), .b_slope(b_slope), .zbuf_rdata(zbuf_rdata), .pix_we(pix_we),
        .pix_addr(pix_addr), .pix_color(pix_color), .pix_z(pix_z), .busy(busy), .done(done)
    );

    // Depth store: combinational read, write on the edge ending the pixel.
    assign zbuf_rdata = zmem[pix_addr[5:0]];
    always @(posedge clk) if (pix_we) zmem[pix_addr[5:0]] <= pix_z;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic longint sx20(input logic [19:0] v);
        return v[19] ? longint'(v) - (longint'(1) << 20) : longint'(v);
    endfunction

    function automatic longint clamp_int(input logic [19:0] i0, input logic [19:0] s, input longint k);
        longint v = longint'(i0) + k * sx20(s);
        if (v < 0) v = 0;
        if (v > 64'hFFFFF) v = 64'hFFFFF;
        return v >>> 12;
    endfunction

    task automatic apply(input vec_t v);
        hold_z = v.fl[4]; hold_color = v.fl[3]; hold_addr = v.fl[2];
        index_mode = v.fl[1]; z_wide = v.fl[0];
        zcmp = v.cmp; door_mask = v.mask; span_cnt = v.cnt;
        base_addr = {14'd0, v.base}; col_phase = v.col; row_phase = v.row;
        z_int = v.z0[35:12]; z_frac_hi = v.z0[11:4]; z_frac_lo = v.z0[3:0];
        zs_int = v.zs[35:12]; zs_frac_hi = v.zs[11:4]; zs_frac_lo = v.zs[3:0];
        r_init = v.r; r_slope = v.rs; g_init = v.g; g_slope = v.gs; b_init = v.b; b_slope = v.bs;
    endtask

    task automatic run_vec(input int idx, input vec_t v);
        int n = (v.cnt < 0) ? -int'(v.cnt) : int'(v.cnt);
        int writes = 0;
        @(negedge clk);
        for (int a = 0; a < 64; a++) zmem[a] = v.fill;
        apply(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < n; k++) begin
            longint dk  = (v.cnt < 0) ? -longint'(k) : longint'(k);
            longint ea  = v.fl[2] ? longint'(v.base) : (longint'(v.base) + dk) & 64'hFFFFF;
            longint zk  = v.fl[4] ? 0 : longint'(k);
            longint ck  = v.fl[3] ? 0 : longint'(k);
            longint zm  = v.fl[0] ? 64'hF_FFFF_FFFF : 64'hFFF_FFFF;
            longint ez  = (((longint'(v.z0) & zm) + zk * longint'(v.zs)) & zm) >> 12;
            longint st  = v.fl[0] ? longint'(zmem[ea[5:0]]) : longint'(zmem[ea[5:0]][15:0]);
            longint xp  = (longint'(v.col) + dk) & 3;
            bit     hit = v.mask[v.row * 4 + int'(xp)];
            bit     pass = (v.cmp[2] && ez < st) || (v.cmp[1] && ez > st) || (v.cmp[0] && ez == st);
            longint er  = v.fl[1] ? 0 : clamp_int(v.r, v.rs, ck);
            longint eg  = v.fl[1] ? 0 : clamp_int(v.g, v.gs, ck);
            longint eb  = clamp_int(v.b, v.bs, ck);
            longint ec  = (er << 16) | (eg << 8) | eb;
            chk(busy == 1'b1, "R1", $sformatf("v%0d px%0d busy", idx, k), busy, 1);
            chk(pix_addr == ea[19:0], v.fl[2] ? "R7" : "R2",
                $sformatf("v%0d px%0d addr", idx, k), pix_addr, ea);
            chk(pix_z == ez[23:0], v.fl[4] ? "R7" : "R3",
                $sformatf("v%0d px%0d z", idx, k), pix_z, ez);
            chk(pix_color == ec[23:0], v.fl[1] ? "R8" : (v.fl[3] ? "R7" : "R6"),
                $sformatf("v%0d px%0d color", idx, k), pix_color, ec);
            chk(pix_we == (pass && !hit), hit ? "R5" : "R4",
                $sformatf("v%0d px%0d we", idx, k), pix_we, pass && !hit);
            if (pix_we) writes++;
            @(negedge clk);
        end
        chk(done == 1'b1 && busy == 1'b0, "R1", $sformatf("v%0d done", idx), {busy, done}, 2'b01);
        chk(writes == int'(v.expw), "R4", $sformatf("v%0d write count", idx), writes, v.expw);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cyc;
        for (int a = 0; a < 64; a++) zmem[a] = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(busy == 1'b0 && done == 1'b0 && pix_we == 1'b0, "R9", "reset outputs",
            {busy, done, pix_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R9", "idle after reset", {busy, done}, 0);

        for (int i = 0; i < NV; i++) run_vec(i, VECS[i]);

        // R1 zero count: done next cycle, no busy, no write
        @(negedge clk);
        apply(VECS[0]);
        span_cnt = 13'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1 && busy == 1'b0 && pix_we == 1'b0, "R1", "zero count",
            {busy, done, pix_we}, 3'b010);
        @(negedge clk);
        chk(done == 1'b0, "R1", "zero count done is one cycle", done, 0);

        // R1 start during a span is ignored
        apply(VECS[0]);
        span_cnt = 13'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        for (int k = 0; k < 20 && busy; k++) begin
            if (k == 2) begin
                span_cnt = 13'd1;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        chk(cyc == 5, "R1", "start while busy ignored (busy cycles)", cyc, 5);
        chk(done == 1'b1, "R1", "done after ignored restart", done, 1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule